// File: doc/BRIEF.md
# Keypad Status and One-Shot Beeper Controller

This block sits between a keypad scanner and a host processor. The scanner hands over a 7-bit key code together with a one-cycle valid strobe. The block holds that code and raises a pending flag, and the flag drives the interrupt line. The host reads the code and the status word at their own addresses. It then writes the acknowledge address, which drops the interrupt. If bit 15 of that write is set, the same write also starts a beep of fixed length.

All timing comes from a slow keypad oscillator. The oscillator reaches the block as a one-cycle enable, `osc_tick`, in the fast clock domain. The oscillator divided by `SCAN_DIV` gives the scan strobe that paces the scanner. The oscillator divided by `TONE_DIV` gives the beep tone. A beep lasts `BEEP_PERIODS` tone periods. The default oscillator is 327,680 Hz, so the defaults give a 2560 Hz scan strobe and a 640 Hz tone that lasts 0.1 s.

Two small state machines do the work:

- **Key machine.** Its states are `KEY_EMPTY` and `KEY_PENDING`.
  - CAPTURE goes from either state to `KEY_PENDING` on a key strobe.
  - ACK goes from `KEY_PENDING` to `KEY_EMPTY` on an acknowledge write with no key strobe in the same cycle.
- **Beeper machine.** Its states are `BEEP_IDLE` and `BEEP_SOUND`.
  - START goes from `BEEP_IDLE` to `BEEP_SOUND` on an acknowledge write with bit 15 set.
  - RESTART stays in `BEEP_SOUND` on another such write and reloads the duration count.
  - EXPIRE goes from `BEEP_SOUND` to `BEEP_IDLE` when the last tick of the last tone period is counted.

Top module: `keypad_beeper_ctrl`

## Requirements
- R1: After reset:
  - the held scancode is 0x7F;
  - the status word is 0;
  - `irq`, `beep_en`, `tone_out` and `scan_tick` are 0.
- R2: A cycle with `key_valid`=1 loads `key_code` into the scancode register and sets status bit 0. From the next cycle `irq` is 1.
- R3: A write to address 2 clears status bit 0, and `irq` is 0 from the next cycle. If `key_valid` is 1 in the same cycle, the new key wins: status bit 0 stays 1 and the new code is held.
- R4: A write to address 2 with data bit 15 = 1 starts the beep, and `beep_en` is 1 from the next cycle. With bit 15 = 0 the beeper state is left as it was, whether idle or sounding.
- R5: Once started, `beep_en` stays 1 for exactly `TONE_DIV`*`BEEP_PERIODS` counted `osc_tick` cycles and then drops by itself. Cycles without `osc_tick` do not advance the duration.
- R6: While sounding, `tone_out` is a square wave:
  - 0 for the first `TONE_DIV`/2 ticks of each tone period, 1 for the second half;
  - one rising edge per period;
  - 0 whenever the beeper is silent.
- R7: A bit-15 acknowledge write while sounding restarts the count. The beep then ends `TONE_DIV`*`BEEP_PERIODS` ticks after that latest write.
- R8: `scan_tick` pulses high for one cycle once every `SCAN_DIV` cycles that carry `osc_tick`.
- R9: A read returns its data one cycle later, with `host_rvalid`=1 and this layout:
  - address 0: the scancode in bits 6:0;
  - address 1: status bit 0 in bit 0;
  - address 2 or 3: zero;
  - all other bits: zero.
  Reads change no state.
- R10: Writes to addresses 0, 1 and 3 are ignored. They change neither the status nor the scancode, and they never start the beeper.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| osc_tick | input | 1 | One-cycle enable per keypad oscillator period |
| key_valid | input | 1 | Scanner strobe: a new key code is present |
| key_code | input | 7 | Key code from the scanner |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 2 | Host register address |
| host_wdata | input | 16 | Host write data; bit 15 requests a beep |
| host_rdata | output | 16 | Registered read data |
| host_rvalid | output | 1 | Read data valid, one cycle after `host_rd` |
| irq | output | 1 | Keypad interrupt request (status bit 0) |
| beep_en | output | 1 | Beeper active |
| tone_out | output | 1 | Square-wave tone, gated by `beep_en` |
| scan_tick | output | 1 | Scan refresh strobe |

## Verification
The assertions check single steps of the state machines on every cycle:
- a capture sets the pending flag and the code;
- an acknowledge with no key strobe clears the flag;
- a start enters the sounding state with the tone count at zero;
- the beeper never stops before its final tick and always stops on it;
- the tone rises at the half period;
- scan pulses never come back to back;
- status reads and ignored writes behave as R9 and R10 describe.

Whole-interval properties can only be shown by the bench scenarios, because no single-cycle property spans them:
- the exact beep length, both with a steady oscillator and with the oscillator paused;
- the count of high tone cycles and rising edges over a whole beep;
- the restart and no-restart lengths;
- the spacing between scan strobes at two oscillator rates.

// File: rtl/kbb_pkg.sv
package kbb_pkg;
    localparam int DATA_W    = 16;
    localparam int CODE_W    = 7;
    localparam int ADDR_W    = 2;
    localparam int START_BIT = 15;

    localparam logic [ADDR_W-1:0] A_SCAN   = 2'd0;
    localparam logic [ADDR_W-1:0] A_STATUS = 2'd1;
    localparam logic [ADDR_W-1:0] A_ACK    = 2'd2;

    localparam logic [CODE_W-1:0] CODE_RESET = 7'h7F;

    typedef enum logic {
        KEY_EMPTY   = 1'b0,
        KEY_PENDING = 1'b1
    } key_state_t;

    typedef enum logic {
        BEEP_IDLE  = 1'b0,
        BEEP_SOUND = 1'b1
    } beep_state_t;
endpackage

// File: rtl/kbb_tick_div.sv
module kbb_tick_div #(
    parameter int DIV = 128
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick_in,
    output logic pulse_out
);
    localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;
    localparam logic [CW-1:0] LAST = CW'(DIV - 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q     <= '0;
            pulse_out <= 1'b0;
        end else begin
            pulse_out <= tick_in && (cnt_q == LAST);
            if (tick_in) begin
                cnt_q <= (cnt_q == LAST) ? '0 : cnt_q + 1'b1;
            end
        end
    end

    generate
        if (DIV > 1) begin : g_spacing
            // R8
            pulse_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
                pulse_out |=> !pulse_out);
        end
    endgenerate
endmodule

// File: rtl/kbb_key_fsm.sv
module kbb_key_fsm
    import kbb_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [CODE_W-1:0] code_in,
    input  logic              ack,
    output logic [CODE_W-1:0] scancode,
    output logic              pending
);
    key_state_t state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            KEY_EMPTY:   if (cap) state_d = KEY_PENDING;
            KEY_PENDING: if (ack && !cap) state_d = KEY_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= KEY_EMPTY;
            scancode <= CODE_RESET;
        end else begin
            state_q <= state_d;
            if (cap) scancode <= code_in;
        end
    end

    always_comb begin
        pending = (state_q == KEY_PENDING);
    end

    // R2
    capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cap |=> pending && (scancode == $past(code_in)));
    // R3
    ack_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && !cap) |=> !pending);
endmodule

// File: rtl/kbb_beep_fsm.sv
module kbb_beep_fsm
    import kbb_pkg::*;
#(
    parameter int TONE_DIV     = 512,
    parameter int BEEP_PERIODS = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic start,
    output logic beep_en,
    output logic tone_out
);
    localparam int TW = $clog2(TONE_DIV);
    localparam int PW = (BEEP_PERIODS > 1) ? $clog2(BEEP_PERIODS) : 1;
    localparam logic [TW-1:0] TONE_LAST = TW'(TONE_DIV - 1);
    localparam logic [TW-1:0] TONE_HALF = TW'(TONE_DIV / 2);
    localparam logic [TW-1:0] TONE_PRE  = TW'(TONE_DIV / 2 - 1);
    localparam logic [PW-1:0] PER_LAST  = PW'(BEEP_PERIODS - 1);

    beep_state_t   state_q, state_d;
    logic [TW-1:0] tone_cnt;
    logic [PW-1:0] per_cnt;
    logic          tone_wrap, run_out;

    assign tone_wrap = osc_tick && (tone_cnt == TONE_LAST);
    assign run_out   = tone_wrap && (per_cnt == PER_LAST);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            BEEP_IDLE:  if (start) state_d = BEEP_SOUND;
            BEEP_SOUND: if (start) state_d = BEEP_SOUND;
                        else if (run_out) state_d = BEEP_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= BEEP_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n || start || state_q == BEEP_IDLE) begin
            tone_cnt <= '0;
            per_cnt  <= '0;
        end else if (osc_tick) begin
            if (tone_wrap) begin
                tone_cnt <= '0;
                per_cnt  <= (per_cnt == PER_LAST) ? '0 : per_cnt + 1'b1;
            end else begin
                tone_cnt <= tone_cnt + 1'b1;
            end
        end
    end

    always_comb begin
        beep_en  = (state_q == BEEP_SOUND);
        tone_out = beep_en && (tone_cnt >= TONE_HALF);
    end

    // R4
    start_sounds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> beep_en && (tone_cnt == '0));
    // R4
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!beep_en && !start) |=> !beep_en);
    // R5
    no_early_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beep_en && !run_out) |=> beep_en);
    // R5
    expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beep_en && run_out && !start) |=> !beep_en);
    // R6
    tone_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (beep_en && !start && osc_tick && tone_cnt == TONE_PRE) |=> tone_out);
endmodule

// File: rtl/keypad_beeper_ctrl.sv
module keypad_beeper_ctrl
    import kbb_pkg::*;
#(
    parameter int TONE_DIV     = 512,
    parameter int BEEP_PERIODS = 64,
    parameter int SCAN_DIV     = 128
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              osc_tick,
    input  logic              key_valid,
    input  logic [CODE_W-1:0] key_code,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_rvalid,
    output logic              irq,
    output logic              beep_en,
    output logic              tone_out,
    output logic              scan_tick
);
    logic              ack, start, key_pending;
    logic [CODE_W-1:0] scancode;
    logic [DATA_W-1:0] rd_mux;
    logic              unused_wbits;

    assign ack          = host_wr && (host_addr == A_ACK);
    assign start        = ack && host_wdata[START_BIT];
    assign unused_wbits = ^host_wdata[START_BIT-1:0];

    kbb_key_fsm u_key (
        .clk      (clk),
        .rst_n    (rst_n),
        .cap      (key_valid),
        .code_in  (key_code),
        .ack      (ack),
        .scancode (scancode),
        .pending  (key_pending)
    );

    kbb_beep_fsm #(
        .TONE_DIV     (TONE_DIV),
        .BEEP_PERIODS (BEEP_PERIODS)
    ) u_beep (
        .clk      (clk),
        .rst_n    (rst_n),
        .osc_tick (osc_tick),
        .start    (start),
        .beep_en  (beep_en),
        .tone_out (tone_out)
    );

    kbb_tick_div #(.DIV(SCAN_DIV)) u_scan (
        .clk       (clk),
        .rst_n     (rst_n),
        .tick_in   (osc_tick),
        .pulse_out (scan_tick)
    );

    always_comb begin
        rd_mux = '0;
        unique case (host_addr)
            A_SCAN:   rd_mux[CODE_W-1:0] = scancode;
            A_STATUS: rd_mux[0]          = key_pending;
            default:  rd_mux             = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            host_rdata  <= '0;
            host_rvalid <= 1'b0;
        end else begin
            host_rvalid <= host_rd;
            host_rdata  <= host_rd ? rd_mux : '0;
        end
    end

    assign irq = key_pending;

    // R9
    status_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && host_addr == A_STATUS) |=>
            host_rvalid && host_rdata == {{(DATA_W-1){1'b0}}, $past(key_pending)});
    // R10
    foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && host_addr != A_ACK && !key_valid) |=>
            (key_pending == $past(key_pending)) && (scancode == $past(scancode)));
endmodule

// File: tb/keypad_beeper_ctrl_tb.sv
module keypad_beeper_ctrl_tb;
    localparam int TD = 8;
    localparam int BP = 4;
    localparam int SD = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        osc_tick = 1'b0;
    logic        key_valid = 1'b0;
    logic [6:0]  key_code = '0;
    logic        host_wr = 1'b0;
    logic        host_rd = 1'b0;
    logic [1:0]  host_addr = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid, irq, beep_en, tone_out, scan_tick;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;
    int osc_mode = 0;   // 0 steady, 1 alternate, 2 stopped

    logic [15:0] exp_val[$];
    string       exp_tag[$];
    logic [15:0] mon_val;
    string       mon_tag;

    keypad_beeper_ctrl #(.TONE_DIV(TD), .BEEP_PERIODS(BP), .SCAN_DIV(SD)) u_dut (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick), .key_valid(key_valid),
        .key_code(key_code), .host_wr(host_wr), .host_rd(host_rd),
        .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
        .host_rvalid(host_rvalid), .irq(irq), .beep_en(beep_en),
        .tone_out(tone_out), .scan_tick(scan_tick)
    );

    always #5 clk = ~clk;

    always @(posedge clk) begin
        #1;
        case (osc_mode)
            0:       osc_tick = 1'b1;
            1:       osc_tick = ~osc_tick;
            default: osc_tick = 1'b0;
        endcase
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops expected read data as the design returns it
    always @(negedge clk) begin
        if (host_rvalid === 1'b1) begin
            if (exp_val.size() == 0) begin
                chk("R9 unexpected read data", 1, 0);
            end else begin
                mon_val = exp_val.pop_front();
                mon_tag = exp_tag.pop_front();
                chk(mon_tag, host_rdata, mon_val);
            end
        end
    end

    task automatic rd(logic [1:0] a, logic [15:0] e, string tag);
        exp_val.push_back(e);
        exp_tag.push_back(tag);
        host_rd = 1'b1; host_addr = a;
        @(posedge clk); #1 host_rd = 1'b0;
    endtask

    task automatic wr(logic [1:0] a, logic [15:0] d);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(posedge clk); #1 host_wr = 1'b0;
    endtask

    task automatic key(logic [6:0] c);
        key_valid = 1'b1; key_code = c;
        @(posedge clk); #1 key_valid = 1'b0;
    endtask

    task automatic idle(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic measure_beep(output int len, output int hi, output int rises);
        logic prev;
        len = 0; hi = 0; rises = 0; prev = 1'b0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (!beep_en) break;
            len++;
            if (tone_out) hi++;
            if (tone_out && !prev) rises++;
            prev = tone_out;
        end
        @(posedge clk); #1;
    endtask

    task automatic scan_gap(output int gap);
        gap = 0;
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            if (scan_tick) break;
        end
        for (int i = 0; i < 100; i++) begin
            @(negedge clk);
            gap++;
            if (scan_tick) break;
        end
        @(posedge clk); #1;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int len, hi, rises, gap;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R1 irq after reset", irq, 0);
        chk("R1 beep_en after reset", beep_en, 0);
        chk("R1 tone_out after reset", tone_out, 0);
        @(posedge clk); #1;
        rd(2'd0, 16'h007F, "R1 scancode after reset");
        rd(2'd1, 16'h0000, "R1 status after reset");

        // R2 capture
        key(7'h15);
        @(negedge clk);
        chk("R2 irq after key", irq, 1);
        @(posedge clk); #1;
        rd(2'd0, 16'h0015, "R2 scancode loaded");
        // R9 reads have no side effects
        rd(2'd1, 16'h0001, "R9 status read 1");
        rd(2'd1, 16'h0001, "R9 status read 2");
        rd(2'd2, 16'h0000, "R9 ack address reads zero");
        rd(2'd3, 16'h0000, "R9 unused address reads zero");
        @(negedge clk);
        chk("R9 irq kept after reads", irq, 1);
        @(posedge clk); #1;

        // R10 foreign writes ignored
        wr(2'd1, 16'h8000);
        wr(2'd3, 16'hFFFF);
        wr(2'd0, 16'h8055);
        @(negedge clk);
        chk("R10 irq after foreign writes", irq, 1);
        chk("R10 no beep from foreign writes", beep_en, 0);
        @(posedge clk); #1;
        rd(2'd0, 16'h0015, "R10 scancode unchanged");

        // R3 ack without beep, R4 bit15=0 leaves idle beeper
        wr(2'd2, 16'h0000);
        @(negedge clk);
        chk("R3 irq cleared by ack", irq, 0);
        chk("R4 no beep with bit15 clear", beep_en, 0);
        @(posedge clk); #1;
        rd(2'd1, 16'h0000, "R3 status cleared");

        // R3 key and ack in the same cycle: key wins
        key_valid = 1'b1; key_code = 7'h2A;
        host_wr = 1'b1; host_addr = 2'd2; host_wdata = 16'h0000;
        @(posedge clk); #1 key_valid = 1'b0; host_wr = 1'b0;
        @(negedge clk);
        chk("R3 key wins over ack", irq, 1);
        @(posedge clk); #1;
        rd(2'd0, 16'h002A, "R3 new code kept");

        // R4/R5/R6 beep
        wr(2'd2, 16'h8000);
        @(negedge clk);
        chk("R4 beep starts", beep_en, 1);
        chk("R3 ack with beep clears irq", irq, 0);
        @(posedge clk); #1;
        measure_beep(len, hi, rises);
        chk("R5 beep length", len + 1, TD * BP);
        chk("R6 tone high cycles", hi, (TD * BP) / 2);
        chk("R6 tone rising edges", rises, BP);
        @(negedge clk);
        chk("R6 tone silent after beep", tone_out, 0);
        @(posedge clk); #1;

        // R7 restart
        wr(2'd2, 16'h8000);
        idle(20);
        @(negedge clk);
        chk("R7 still sounding before restart", beep_en, 1);
        @(posedge clk); #1;
        wr(2'd2, 16'h8000);
        measure_beep(len, hi, rises);
        chk("R7 length after restart", len, TD * BP);

        // R4 bit15=0 while sounding does not restart
        wr(2'd2, 16'h8000);
        idle(9);
        wr(2'd2, 16'h0000);
        measure_beep(len, hi, rises);
        chk("R4 no restart with bit15 clear", len, TD * BP - 10);

        // R5 oscillator paused
        osc_mode = 2;
        idle(3);
        wr(2'd2, 16'h8000);
        idle(50);
        @(negedge clk);
        chk("R5 beep holds with oscillator stopped", beep_en, 1);
        chk("R6 tone low at period start", tone_out, 0);
        osc_mode = 0;
        @(posedge clk); #1;
        measure_beep(len, hi, rises);
        chk("R5 length once oscillator resumes", len, TD * BP);

        // R8 scan strobe spacing
        idle(5);
        scan_gap(gap);
        chk("R8 scan spacing steady oscillator", gap, SD);
        osc_mode = 1;
        idle(20);
        scan_gap(gap);
        chk("R8 scan spacing half-rate oscillator", gap, 2 * SD);
        osc_mode = 0;

        idle(4);
        chk("R9 all reads returned", exp_val.size(), 0);
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule